// File: doc/BRIEF.md
# Serial Memory Bus Slave Front End

This block is the two-wire bus slave for a 16 KiB serial memory. It oversamples the bus clock and data lines in the system clock domain and finds START and STOP conditions. It then checks the device address and loads a 14-bit byte pointer from two address bytes. It pulls the data line low through an open-drain enable to acknowledge bytes and to shift read data out. Read data comes from the memory array through a plain address/data pair. Write data leaves through a valid/ready stream toward a separate page buffer. A one-cycle commit strobe tells the page buffer when a complete write sequence has ended.

There are three ways to read. An immediate read starts at the current pointer. A selective read loads two address bytes, issues a repeated START and then reads. A sequential read keeps going for as long as the master acknowledges. A busy input blocks the device address while the memory performs its internal write. A write-protect input is sampled at one bus clock edge and can refuse a whole write.

Stream rules on the write side: `wr_valid` rises a few system clocks after the bus clock edge that carries the last bit of a data byte. It holds `wr_addr` and `wr_data` steady until `wr_ready` is seen high or the next bus clock falling edge arrives, whichever comes first. A byte the sink takes is acknowledged on the bus. A byte the sink has not taken by that falling edge is withdrawn and not acknowledged, and the rest of that write is dropped. `rd_data` is sampled only on bus clock falling edges, at least half a bus clock period after `rd_addr` last moved.

Top module: `i2c_mem_slave`

## Requirements
- R1: The device address byte is accepted only when its upper seven bits equal 1010 followed by `strap_i[2:0]`; bit 0 is the read flag (1 = read). On a mismatch the slave does not acknowledge, and it leaves SDA released until the next START.
- R2: On a write, the slave acknowledges the device address and two address bytes. The pointer is loaded with {first byte bits 5:0, second byte}, and bits 7:6 of the first byte are ignored.
- R3: Each data byte in a write is presented on `wr_addr`/`wr_data` with the pointer value at the time it was received, and it is acknowledged once the sink takes it.
- R4: After each write byte is taken, the pointer advances inside its 64-byte page: bits 5:0 wrap from 63 to 0 and bits 13:6 stay the same. A later immediate read therefore starts one past the last written byte, counted within that page.
- R5: `wr_commit` pulses for one clock after a STOP that ends a write in which at least one byte was taken and none was refused.
- R6: For a read, the slave acknowledges the address and shifts out the byte at the current pointer, most significant bit first, starting on the falling edge that ends the acknowledge.
- R7: After each read byte the pointer advances over the full 14-bit space and wraps from 0x3FFF to 0x0000. When the master acknowledges, the next byte follows. When the master does not acknowledge, SDA stays released until START or STOP.
- R8: In a selective read (address bytes with no data, then a repeated START and a read address), data starts at the newly loaded pointer.
- R9: While `busy_i` is high, the device address is not acknowledged.
- R10: `wp_i` is sampled on the falling bus clock edge that ends the acknowledge of the second address byte. If it is high there, the first data byte is not acknowledged, nothing is presented on the stream and no commit follows. Changes to `wp_i` after that edge have no effect on the current write.
- R11: If the sink does not take a byte before the next falling bus clock edge, that byte is not acknowledged, the rest of the write is ignored and no commit follows.
- R12: START or STOP aborts any byte in progress. A START always restarts device-address reception with SDA released.
- R13: After reset, SDA is released and `wr_valid` and `wr_commit` are low. The SDA drive changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | High pulls the data line low |
| strap_i | input | 3 | Low three bits of the device address |
| wp_i | input | 1 | Write protect, high refuses writes |
| busy_i | input | 1 | Internal write cycle in progress |
| wr_valid | output | 1 | Write byte offered |
| wr_ready | input | 1 | Sink takes the offered byte |
| wr_addr | output | 14 | Byte address of the offered byte |
| wr_data | output | 8 | Offered byte |
| wr_commit | output | 1 | One-clock pulse: write sequence complete |
| rd_addr | output | 14 | Current pointer, address for read data |
| rd_data | input | 8 | Memory byte at `rd_addr` |

## Verification
The hardest case to reach is the write-protect sampling edge. The protect input has to change between the falling edge that closes the second address acknowledge and the first data bit. To get there, the stimulus drives the bus bit by bit and raises `wp_i` only after the acknowledge clock has fully completed, then checks that the write is still accepted and lands in memory. A bench memory model fed by the write stream and the commit strobe predicts every read byte. A behavioural pointer tracks page wrap on writes and full wrap on reads. A monitor watches every clock that the SDA drive never moves while the bus clock is high.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_RACK,
    ST_RNXT,
    ST_SKIP
  } phase_t;
endpackage

// File: rtl/i2c_mem_line_cond.sv
module i2c_mem_line_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_in};
      sda_p <= {sda_p[STAGES-2:0], sda_in};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_mem_addr_ctr.sv
module i2c_mem_addr_ctr #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else if (load) addr <= load_val;
    else if (inc_full) addr <= addr + ONE_A;
    else if (inc_page) addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + ONE_P};
  end

  // R4: a write step never leaves the page
  a_r4_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !load && !inc_full) |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
  // R7: read step wraps at the end of the space
  a_r7_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_full && !load && (&addr)) |=> addr == '0);
endmodule

// File: rtl/i2c_mem_wr_port.sv
module i2c_mem_wr_port #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer,
  input  logic [ADDR_W-1:0] offer_addr,
  input  logic [DATA_W-1:0] offer_data,
  input  logic              withdraw,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              taken
);
  logic took_q;
  logic hs;

  assign hs    = valid & ready;
  assign taken = took_q | hs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr   <= '0;
      data   <= '0;
      took_q <= 1'b0;
    end else if (offer) begin
      valid  <= 1'b1;
      addr   <= offer_addr;
      data   <= offer_data;
      took_q <= 1'b0;
    end else if (withdraw) begin
      valid  <= 1'b0;
      took_q <= 1'b0;
    end else if (hs) begin
      valid  <= 1'b0;
      took_q <= 1'b1;
    end
  end

  // R11: an offered byte stays put until taken or withdrawn
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !withdraw && !offer) |=> valid && $stable(data) && $stable(addr));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned PAGE_W      = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [3:0]  DEV_PREFIX  = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              wp_i,
  input  logic              busy_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int unsigned HI_W = ADDR_W - 8;

  logic scl_s, sda_s, rise, fall, start_det, stop_det;
  phase_t ph;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic [HI_W-1:0] ahi_q;
  logic in_ack, oe, rdmode, wp_lat, wr_any, wr_bad, commit_q;
  logic byte_full, dev_hit;
  logic ld, inc_full, offer, withdraw, wr_taken;

  i2c_mem_line_cond #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(rise), .scl_fall(fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_full = (bitn == 4'd8);
  assign dev_hit   = (sh[7:1] == {DEV_PREFIX, strap_i}) && !busy_i;
  assign ld        = (ph == ST_ALO) && !in_ack && fall && byte_full;
  assign inc_full  = (ph == ST_RDAT) && fall && byte_full;
  assign offer     = (ph == ST_WDAT) && !in_ack && rise && (bitn == 4'd7) && !wp_lat;
  assign withdraw  = ((ph == ST_WDAT) && !in_ack && fall && byte_full) || start_det || stop_det;

  i2c_mem_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val({ahi_q, sh}),
    .inc_page(wr_valid & wr_ready), .inc_full(inc_full), .addr(rd_addr)
  );

  i2c_mem_wr_port #(.ADDR_W(ADDR_W), .DATA_W(8)) u_wr (
    .clk(clk), .rst_n(rst_n), .offer(offer), .offer_addr(rd_addr),
    .offer_data({sh[6:0], sda_s}), .withdraw(withdraw), .ready(wr_ready),
    .valid(wr_valid), .addr(wr_addr), .data(wr_data), .taken(wr_taken)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= ST_IDLE;
      bitn     <= '0;
      sh       <= '0;
      ahi_q    <= '0;
      in_ack   <= 1'b0;
      oe       <= 1'b0;
      rdmode   <= 1'b0;
      wp_lat   <= 1'b0;
      wr_any   <= 1'b0;
      wr_bad   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (start_det) begin
        ph     <= ST_DEV;
        bitn   <= '0;
        in_ack <= 1'b0;
        oe     <= 1'b0;
        wr_any <= 1'b0;
        wr_bad <= 1'b0;
      end else if (stop_det) begin
        ph       <= ST_IDLE;
        in_ack   <= 1'b0;
        oe       <= 1'b0;
        commit_q <= wr_any & ~wr_bad;
        wr_any   <= 1'b0;
        wr_bad   <= 1'b0;
      end else if (in_ack) begin
        if (fall) begin
          in_ack <= 1'b0;
          oe     <= 1'b0;
          bitn   <= '0;
          case (ph)
            ST_DEV: begin
              if (rdmode) begin
                ph <= ST_RDAT;
                sh <= rd_data;
                oe <= ~rd_data[7];
              end else begin
                ph <= ST_AHI;
              end
            end
            ST_AHI: ph <= ST_ALO;
            ST_ALO: begin
              ph     <= ST_WDAT;
              wp_lat <= wp_i;
            end
            default: ;
          endcase
        end
      end else begin
        case (ph)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (rise && !byte_full) begin
              sh   <= {sh[6:0], sda_s};
              bitn <= bitn + 4'd1;
            end else if (fall && byte_full) begin
              case (ph)
                ST_DEV: begin
                  rdmode <= sh[0];
                  if (dev_hit) begin
                    oe     <= 1'b1;
                    in_ack <= 1'b1;
                  end else begin
                    ph <= ST_SKIP;
                  end
                end
                ST_AHI: begin
                  ahi_q  <= sh[HI_W-1:0];
                  oe     <= 1'b1;
                  in_ack <= 1'b1;
                end
                ST_ALO: begin
                  oe     <= 1'b1;
                  in_ack <= 1'b1;
                end
                default: begin
                  if (!wp_lat && wr_taken) begin
                    oe     <= 1'b1;
                    in_ack <= 1'b1;
                    wr_any <= 1'b1;
                  end else begin
                    ph     <= ST_SKIP;
                    wr_bad <= 1'b1;
                  end
                end
              endcase
            end
          end
          ST_RDAT: begin
            if (rise) begin
              bitn <= bitn + 4'd1;
            end else if (fall) begin
              if (byte_full) begin
                oe <= 1'b0;
                ph <= ST_RACK;
              end else begin
                sh <= {sh[6:0], 1'b0};
                oe <= ~sh[6];
              end
            end
          end
          ST_RACK: if (rise) ph <= sda_s ? ST_SKIP : ST_RNXT;
          ST_RNXT: begin
            if (fall) begin
              ph   <= ST_RDAT;
              bitn <= '0;
              sh   <= rd_data;
              oe   <= ~rd_data[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe    = oe;
  assign wr_commit = commit_q;

  // R13: drive moves only with the bus clock low
  a_r13_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != $past(oe)) |-> !scl_s);
  // R9: busy refuses the device address
  a_r9_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == ST_DEV && !in_ack && fall && byte_full && busy_i) |=> (!oe && ph == ST_SKIP));
  // R12: START restarts address reception, released
  a_r12_start_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (ph == ST_DEV && !oe && bitn == 4'd0));
  // R1: a skipped transfer keeps the line released
  a_r1_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == ST_SKIP) |-> !oe);
endmodule

// File: tb/i2c_mem_slave_tb_top.sv
module i2c_mem_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m, wp, busy, wr_ready;
  logic sda_oe, wr_valid, wr_commit;
  logic [13:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  wire bus_sda = sda_m & ~sda_oe;

  int nchk = 0, nerr = 0, ncommit = 0, viol = 0;
  bit done = 0, sawv = 0, prev_oe = 0;
  int exp_ptr = 0;
  logic [7:0] mem [int];
  int pa [$];
  logic [7:0] pd [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda), .sda_oe(sda_oe),
    .strap_i(STRAP), .wp_i(wp), .busy_i(busy), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] peek(int a);
    if (mem.exists(a)) return mem[a];
    return 8'((a * 7 + 3) & 255);
  endfunction

  always @(posedge clk) rd_data <= peek(int'(rd_addr));

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      pa.push_back(int'(wr_addr));
      pd.push_back(wr_data);
    end
    if (wr_commit) begin
      ncommit++;
      foreach (pa[i]) mem[pa[i]] = pd[i];
      pa.delete();
      pd.delete();
    end
  end

  always @(negedge clk) begin
    if (rst_n && (sda_oe != prev_oe) && scl_m) viol++;
    prev_oe = sda_oe;
    if (wr_valid) sawv = 1;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    s = bus_sda; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    pa.delete(); pd.delete();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(!mack, s);
  endtask

  function automatic int step_page(int p);
    return (p & ~63) | ((p + 1) & 63);
  endfunction

  task automatic addr_phase(input logic [7:0] hi, input logic [7:0] lo, input string tag);
    bit ack;
    send_byte(DEVW, ack); check(ack, {tag, " dev ack"}, ack, 1);
    send_byte(hi, ack);   check(ack, {tag, " hi ack"}, ack, 1);
    send_byte(lo, ack);   check(ack, {tag, " lo ack"}, ack, 1);
    exp_ptr = {hi[5:0], lo};
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    int c0;
    logic [7:0] wbytes [3];
    scl_m = 1; sda_m = 1; wp = 0; busy = 0; wr_ready = 1; rst_n = 0;
    tick(5); rst_n = 1; tick(5);
    check(!sda_oe && !wr_valid && !wr_commit, "R13 reset released", {sda_oe, wr_valid, wr_commit}, 0);

    // R1: strap mismatch
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b0}, ack); check(!ack, "R1 wrong strap nack", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R1 released until START", ack, 0);
    bus_stop();

    // R2 R3 R5: write three bytes at 0x0010, top address bits set
    c0 = ncommit;
    bus_start();
    addr_phase(8'hC0, 8'h10, "R2");
    check(exp_ptr == 16, "R2 top bits ignored", exp_ptr, 16);
    wbytes = '{8'hA1, 8'hB2, 8'hC3};
    foreach (wbytes[i]) begin
      send_byte(wbytes[i], ack); check(ack, "R3 data ack", ack, 1);
      exp_ptr = step_page(exp_ptr);
    end
    check(pa.size() == 3 && pa[0] == 'h10 && pa[2] == 'h12, "R3 stream addresses", pa.size(), 3);
    check(pd.size() == 3 && pd[1] == 8'hB2, "R3 stream data", pd.size() == 3 ? int'(pd[1]) : -1, 'hB2);
    bus_stop(); tick(4);
    check(ncommit == c0 + 1, "R5 commit after STOP", ncommit, c0 + 1);

    // R6 R4: immediate read starts one past the last written byte
    bus_start();
    send_byte(DEVR, ack); check(ack, "R6 read address ack", ack, 1);
    recv_byte(0, b); check(b == peek(exp_ptr), "R6 R4 immediate read", b, peek(exp_ptr));
    exp_ptr = (exp_ptr + 1) & 16383;
    bus_stop();

    // R8 R7: selective then sequential read at 0x0010
    bus_start();
    addr_phase(8'h00, 8'h10, "R8");
    bus_start();
    send_byte(DEVR, ack); check(ack, "R8 repeated start ack", ack, 1);
    for (int i = 0; i < 4; i++) begin
      recv_byte(i < 3, b);
      check(b == peek(exp_ptr), "R8 R7 sequential byte", b, peek(exp_ptr));
      exp_ptr = (exp_ptr + 1) & 16383;
    end
    bus_stop();

    // R4: page wrap on write starting at 0x007E
    bus_start();
    addr_phase(8'h00, 8'h7E, "R4");
    wbytes = '{8'h11, 8'h22, 8'h33};
    foreach (wbytes[i]) begin
      send_byte(wbytes[i], ack); check(ack, "R4 data ack", ack, 1);
      exp_ptr = step_page(exp_ptr);
    end
    check(pa.size() == 3 && pa[1] == 'h7F && pa[2] == 'h40, "R4 page wrap", pa.size() == 3 ? pa[2] : -1, 'h40);
    bus_stop(); tick(4);
    bus_start();
    send_byte(DEVR, ack);
    recv_byte(0, b); check(b == peek(exp_ptr), "R4 pointer after wrap", b, peek(exp_ptr));
    exp_ptr = (exp_ptr + 1) & 16383;
    bus_stop();

    // R7: full wrap at end of space
    bus_start();
    addr_phase(8'hFF, 8'hFF, "R7");
    bus_start();
    send_byte(DEVR, ack);
    recv_byte(1, b); check(b == peek(16383), "R7 last address", b, peek(16383));
    recv_byte(0, b); check(b == peek(0), "R7 wrap to zero", b, peek(0));
    tick(2); check(!sda_oe, "R7 released after nack", sda_oe, 0);
    exp_ptr = 1;
    bus_stop();

    // R9: busy
    busy = 1;
    bus_start();
    send_byte(DEVW, ack); check(!ack, "R9 busy nack", ack, 0);
    bus_stop();
    busy = 0;

    // R10: protect high at the sample edge
    c0 = ncommit; wp = 1; sawv = 0;
    bus_start();
    addr_phase(8'h01, 8'h00, "R10");
    send_byte(8'h5A, ack); check(!ack, "R10 protected data nack", ack, 0);
    check(!sawv, "R10 nothing offered", sawv, 0);
    bus_stop(); tick(4);
    check(ncommit == c0, "R10 no commit", ncommit, c0);
    wp = 0;

    // R10: protect raised after the sample edge has no effect
    c0 = ncommit;
    bus_start();
    addr_phase(8'h01, 8'h08, "R10");
    wp = 1;
    send_byte(8'h77, ack); check(ack, "R10 late protect ignored", ack, 1);
    bus_stop(); tick(4); wp = 0;
    check(ncommit == c0 + 1, "R10 late protect commit", ncommit, c0 + 1);

    // R11: sink never ready
    c0 = ncommit; wr_ready = 0; sawv = 0;
    bus_start();
    addr_phase(8'h02, 8'h00, "R11");
    send_byte(8'h99, ack); check(!ack, "R11 untaken byte nack", ack, 0);
    check(sawv, "R11 byte was offered", sawv, 1);
    send_byte(8'h98, ack); check(!ack, "R11 rest ignored", ack, 0);
    bus_stop(); tick(4);
    check(ncommit == c0, "R11 no commit", ncommit, c0);
    wr_ready = 1;

    // R12: STOP in the middle of a byte, then a clean read
    bus_start();
    begin
      logic s;
      bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
    end
    bus_stop();
    bus_start();
    send_byte(DEVR, ack); check(ack, "R12 ack after abort", ack, 1);
    recv_byte(0, b); check(b == peek(exp_ptr), "R12 read after abort", b, peek(exp_ptr));
    bus_stop();

    // R10: memory content after both protect cases
    bus_start();
    addr_phase(8'h01, 8'h08, "R10");
    bus_start();
    send_byte(DEVR, ack);
    recv_byte(0, b); check(b == 8'h77, "R10 late protect data stored", b, 'h77);
    bus_stop();
    check(peek('h100) == 8'((256 * 7 + 3) & 255), "R10 protected byte not stored", peek('h100), (256 * 7 + 3) & 255);

    check(viol == 0, "R13 drive moved with clock high", viol, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule